// File: doc/BRIEF.md
# DMA Channel Major-Loop Control

This block holds the control and status state of one channel in a descriptor-driven DMA engine. It tracks whether the channel is waiting for service, is moving a minor loop, or has finished its whole major loop. It also keeps the current and beginning iteration counts, the enables for linking, scatter/gather and interrupts, and the number of the channel to link to. The data mover reports three things as single-cycle strobes: service has begun, a minor loop has finished, or a transfer error has occurred. The block answers with single-cycle event pulses: a half-way interrupt, a major-complete interrupt, a clear for the channel's hardware request enable, a start request to a linked channel, and either a descriptor-fetch request or an alignment error.

Software writes one control word that carries the start, done and enable fields and the link channel number. A separate write loads the iteration count into both the current and the beginning counter, and another write loads the scatter/gather pointer. While the channel shows done, a control write cannot turn on linking or scatter/gather. Software must first clear done and then enable them in a later write.

The channel sequence is a three-state machine. `CH_IDLE` means nothing is running and done is clear. `CH_BUSY` means a minor loop is in progress, and the active flag is this state. `CH_DONE` means the major loop has completed, and the done flag is this state. The transitions are:
- IDLE→BUSY on service begin.
- DONE→BUSY on service begin, which clears done.
- IDLE→DONE on a control write with done=1.
- DONE→IDLE on a control write with done=0.
- BUSY→IDLE on an error, or on a minor loop that is not the last one.
- BUSY→DONE on the last minor loop.

Top module: `dma_major_ctl`

## Requirements
- R1: `done_o` is 1 exactly when the channel is in the completed state. It rises one cycle after the last minor-loop strobe. It clears one cycle after an accepted `svc_begin`, or after a control write with `cfg_done`=0 while the channel is not busy. A control write with `cfg_done`=1 while the channel is idle sets it.
- R2: A control write made while `done_o`=1 stores 0 into both `link_en_o` and `sg_en_o`, whatever values are written. When `done_o`=0, the written values are stored.
- R3: `active_o` rises one cycle after `svc_begin` is seen while the channel is not busy. It falls one cycle after `minor_done` or `xfer_err` is seen while busy. `xfer_err` takes priority and leaves the counts unchanged. `svc_begin` while busy and `minor_done` while not busy have no effect.
- R4: `start_o` is set by a control write with `cfg_start`=1 or by `link_start_in`. A control write with `cfg_start`=0 clears it. An accepted `svc_begin` clears it, and this clear wins over a set in the same cycle.
- R5: With `cfg_half_ie` stored as 1, `irq_half` pulses when a minor loop leaves `citer_o` equal to `biter_o` shifted right by one. It never pulses when `biter_o` is below 2.
- R6: With `cfg_major_ie` stored as 1, `irq_major` pulses on major-loop completion, in the same cycle that `done_o` rises.
- R7: With `cfg_req_dis` stored as 1, `req_en_clr` pulses on major-loop completion. With it stored as 0, `req_en_clr` stays 0.
- R8: With linking enabled, `link_start_out` pulses on major-loop completion, and `link_target` carries the stored link channel number.
- R9: With scatter/gather enabled and the pointer's low log2(`DESC_BYTES`) bits all zero, `sg_fetch_req` pulses on major-loop completion, and `sg_fetch_addr` carries the pointer.
- R10: Each accepted minor loop lowers `citer_o` by one. A loop taken with `citer_o` at 1 or 0 is the last one and reloads `citer_o` from `biter_o`. An iteration write loads both counters and is ignored in a cycle where a minor loop is accepted.
- R11: With scatter/gather enabled and a misaligned pointer, major-loop completion pulses `sg_align_err` instead of `sg_fetch_req`. The two never pulse together.
- R12: All event pulses last exactly one cycle. When they coincide, they appear together in the cycle after the minor-loop strobe.
- R13: After reset the channel is idle. All flags, enables, counters, the pointer and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_start | input | 1 | Written start flag |
| cfg_done | input | 1 | Written done flag |
| cfg_link_en | input | 1 | Written major-link enable |
| cfg_sg_en | input | 1 | Written scatter/gather enable |
| cfg_half_ie | input | 1 | Written half-point interrupt enable |
| cfg_major_ie | input | 1 | Written major-complete interrupt enable |
| cfg_req_dis | input | 1 | Written request-disable-on-completion flag |
| cfg_link_ch | input | LINK_W | Written link target channel |
| iter_wr | input | 1 | Iteration count write strobe |
| iter_val | input | ITER_W | Iteration count for both counters |
| sga_wr | input | 1 | Scatter/gather pointer write strobe |
| sga_val | input | ADDR_W | Scatter/gather pointer value |
| link_start_in | input | 1 | Start request from another channel |
| svc_begin | input | 1 | Engine: channel service begins |
| minor_done | input | 1 | Engine: minor loop complete |
| xfer_err | input | 1 | Engine: error during service |
| start_o | output | 1 | Start flag |
| active_o | output | 1 | Active flag |
| done_o | output | 1 | Done flag |
| link_en_o | output | 1 | Stored major-link enable |
| sg_en_o | output | 1 | Stored scatter/gather enable |
| citer_o | output | ITER_W | Current iteration count |
| biter_o | output | ITER_W | Beginning iteration count |
| irq_half | output | 1 | Half-point interrupt pulse |
| irq_major | output | 1 | Major-complete interrupt pulse |
| req_en_clr | output | 1 | Clear pulse for the hardware request enable |
| link_start_out | output | 1 | Start pulse to the linked channel |
| link_target | output | LINK_W | Linked channel number |
| sg_fetch_req | output | 1 | Descriptor fetch request pulse |
| sg_fetch_addr | output | ADDR_W | Descriptor fetch address |
| sg_align_err | output | 1 | Misaligned pointer error pulse |

## Verification
The bench builds the block with a 5-bit iteration count, a 6-bit link field, a 16-bit pointer and 32-byte descriptors. The narrow count lets one run cover the full range. That includes the largest count of 31, whose half point at 15 checks the truncating shift on an odd value, together with the edge counts 0, 1, 2 and 3. The 6-bit link field carries a channel number above 31, and the short pointer still leaves room for both aligned and misaligned addresses.

// File: rtl/dma_major_pkg.sv
package dma_major_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_BUSY = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic half;
        logic major;
        logic req_clr;
        logic link;
        logic sg_go;
        logic sg_bad;
    } ch_evt_t;

endpackage

// File: rtl/dma_major_fsm.sv
module dma_major_fsm
    import dma_major_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      svc_begin,
    input  logic      minor_done,
    input  logic      xfer_err,
    input  logic      last_iter,
    input  logic      cfg_wr,
    input  logic      cfg_done,
    output ch_state_e state,
    output logic      accept_svc,
    output logic      accept_minor
);

    ch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (svc_begin)              state_d = CH_BUSY;
                else if (cfg_wr && cfg_done) state_d = CH_DONE;
            end
            CH_BUSY: begin
                if (xfer_err)               state_d = CH_IDLE;
                else if (minor_done)        state_d = last_iter ? CH_DONE : CH_IDLE;
            end
            CH_DONE: begin
                if (svc_begin)               state_d = CH_BUSY;
                else if (cfg_wr && !cfg_done) state_d = CH_IDLE;
            end
            default:                        state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        state        = state_q;
        accept_svc   = (state_q != CH_BUSY) && svc_begin;
        accept_minor = (state_q == CH_BUSY) && minor_done && !xfer_err;
    end

    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_BUSY && (minor_done || xfer_err)) |=> (state_q != CH_BUSY)); // R3
    AST_SVC_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        accept_svc |=> (state_q == CH_BUSY)); // R3
    AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_minor && last_iter) |=> (state_q == CH_DONE)); // R1

endmodule

// File: rtl/dma_major_iter.sv
module dma_major_iter #(
    parameter int ITER_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iter_wr,
    input  logic [ITER_W-1:0] iter_val,
    input  logic              step,
    output logic [ITER_W-1:0] citer,
    output logic [ITER_W-1:0] biter,
    output logic              last_iter,
    output logic              half_hit
);

    localparam logic [ITER_W-1:0] ONE = ITER_W'(1);

    logic [ITER_W-1:0] citer_q, biter_q, cnt_next;

    assign last_iter = (citer_q <= ONE);
    assign cnt_next  = last_iter ? '0 : (citer_q - ONE);
    assign half_hit  = (biter_q > ONE) && (cnt_next == (biter_q >> 1));
    assign citer     = citer_q;
    assign biter     = biter_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            citer_q <= '0;
            biter_q <= '0;
        end else if (step) begin
            citer_q <= last_iter ? biter_q : cnt_next;
        end else if (iter_wr) begin
            citer_q <= iter_val;
            biter_q <= iter_val;
        end
    end

    AST_CITER_LE_BITER: assert property (@(posedge clk) disable iff (!rst_n)
        citer_q <= biter_q); // R10
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_iter) |=> (citer_q == $past(biter_q))); // R10
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last_iter) |=> (citer_q == $past(citer_q) - ONE)); // R10

endmodule

// File: rtl/dma_major_flags.sv
module dma_major_flags #(
    parameter int LINK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_start,
    input  logic              cfg_link_en,
    input  logic              cfg_sg_en,
    input  logic              cfg_half_ie,
    input  logic              cfg_major_ie,
    input  logic              cfg_req_dis,
    input  logic [LINK_W-1:0] cfg_link_ch,
    input  logic              done_now,
    input  logic              link_start_in,
    input  logic              accept_svc,
    output logic              start,
    output logic              link_en,
    output logic              sg_en,
    output logic              half_ie,
    output logic              major_ie,
    output logic              req_dis,
    output logic [LINK_W-1:0] link_ch
);

    logic              start_q, link_en_q, sg_en_q, half_ie_q, major_ie_q, req_dis_q;
    logic [LINK_W-1:0] link_ch_q;
    logic              start_d;

    always_comb begin
        if (accept_svc)         start_d = 1'b0;
        else if (link_start_in) start_d = 1'b1;
        else if (cfg_wr)        start_d = cfg_start;
        else                    start_d = start_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= 1'b0;
            link_en_q  <= 1'b0;
            sg_en_q    <= 1'b0;
            half_ie_q  <= 1'b0;
            major_ie_q <= 1'b0;
            req_dis_q  <= 1'b0;
            link_ch_q  <= '0;
        end else begin
            start_q <= start_d;
            if (cfg_wr) begin
                link_en_q  <= cfg_link_en & ~done_now;
                sg_en_q    <= cfg_sg_en & ~done_now;
                half_ie_q  <= cfg_half_ie;
                major_ie_q <= cfg_major_ie;
                req_dis_q  <= cfg_req_dis;
                link_ch_q  <= cfg_link_ch;
            end
        end
    end

    assign start    = start_q;
    assign link_en  = link_en_q;
    assign sg_en    = sg_en_q;
    assign half_ie  = half_ie_q;
    assign major_ie = major_ie_q;
    assign req_dis  = req_dis_q;
    assign link_ch  = link_ch_q;

    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && done_now) |=> (!link_en_q && !sg_en_q)); // R2
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        accept_svc |=> !start_q); // R4

endmodule

// File: rtl/dma_major_evt.sv
module dma_major_evt
    import dma_major_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sga_wr,
    input  logic [ADDR_W-1:0] sga_val,
    input  logic              step,
    input  logic              last_iter,
    input  logic              half_hit,
    input  logic              half_ie,
    input  logic              major_ie,
    input  logic              req_dis,
    input  logic              link_en,
    input  logic              sg_en,
    output ch_evt_t           evt,
    output logic [ADDR_W-1:0] sga
);

    localparam int ALIGN_W = $clog2(DESC_BYTES);

    logic [ADDR_W-1:0] sga_q;
    logic              aligned;
    ch_evt_t           evt_q, evt_d;

    generate
        if (ALIGN_W > 0) begin : g_align
            assign aligned = (sga_q[ALIGN_W-1:0] == '0);
        end else begin : g_noalign
            assign aligned = 1'b1;
        end
    endgenerate

    always_comb begin
        evt_d = '0;
        if (step) begin
            evt_d.half    = half_ie && half_hit;
            evt_d.major   = major_ie && last_iter;
            evt_d.req_clr = req_dis && last_iter;
            evt_d.link    = link_en && last_iter;
            evt_d.sg_go   = sg_en && last_iter && aligned;
            evt_d.sg_bad  = sg_en && last_iter && !aligned;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sga_q <= '0;
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
            if (sga_wr) sga_q <= sga_val;
        end
    end

    assign evt = evt_q;
    assign sga = sga_q;

    AST_SG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_q.sg_go && evt_q.sg_bad)); // R11
    AST_MAJOR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.major |=> !evt_q.major); // R12
    AST_LINK_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.link |=> !evt_q.link); // R12

endmodule

// File: rtl/dma_major_ctl.sv
module dma_major_ctl
    import dma_major_pkg::*;
#(
    parameter int ITER_W     = 15,
    parameter int LINK_W     = 6,
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_start,
    input  logic              cfg_done,
    input  logic              cfg_link_en,
    input  logic              cfg_sg_en,
    input  logic              cfg_half_ie,
    input  logic              cfg_major_ie,
    input  logic              cfg_req_dis,
    input  logic [LINK_W-1:0] cfg_link_ch,
    input  logic              iter_wr,
    input  logic [ITER_W-1:0] iter_val,
    input  logic              sga_wr,
    input  logic [ADDR_W-1:0] sga_val,
    input  logic              link_start_in,
    input  logic              svc_begin,
    input  logic              minor_done,
    input  logic              xfer_err,
    output logic              start_o,
    output logic              active_o,
    output logic              done_o,
    output logic              link_en_o,
    output logic              sg_en_o,
    output logic [ITER_W-1:0] citer_o,
    output logic [ITER_W-1:0] biter_o,
    output logic              irq_half,
    output logic              irq_major,
    output logic              req_en_clr,
    output logic              link_start_out,
    output logic [LINK_W-1:0] link_target,
    output logic              sg_fetch_req,
    output logic [ADDR_W-1:0] sg_fetch_addr,
    output logic              sg_align_err
);

    ch_state_e state;
    logic      accept_svc, accept_minor, last_iter, half_hit;
    logic      half_ie, major_ie, req_dis;
    ch_evt_t   evt;

    dma_major_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .svc_begin    (svc_begin),
        .minor_done   (minor_done),
        .xfer_err     (xfer_err),
        .last_iter    (last_iter),
        .cfg_wr       (cfg_wr),
        .cfg_done     (cfg_done),
        .state        (state),
        .accept_svc   (accept_svc),
        .accept_minor (accept_minor)
    );

    dma_major_iter #(.ITER_W(ITER_W)) u_iter (
        .clk       (clk),
        .rst_n     (rst_n),
        .iter_wr   (iter_wr),
        .iter_val  (iter_val),
        .step      (accept_minor),
        .citer     (citer_o),
        .biter     (biter_o),
        .last_iter (last_iter),
        .half_hit  (half_hit)
    );

    dma_major_flags #(.LINK_W(LINK_W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_start     (cfg_start),
        .cfg_link_en   (cfg_link_en),
        .cfg_sg_en     (cfg_sg_en),
        .cfg_half_ie   (cfg_half_ie),
        .cfg_major_ie  (cfg_major_ie),
        .cfg_req_dis   (cfg_req_dis),
        .cfg_link_ch   (cfg_link_ch),
        .done_now      (done_o),
        .link_start_in (link_start_in),
        .accept_svc    (accept_svc),
        .start         (start_o),
        .link_en       (link_en_o),
        .sg_en         (sg_en_o),
        .half_ie       (half_ie),
        .major_ie      (major_ie),
        .req_dis       (req_dis),
        .link_ch       (link_target)
    );

    dma_major_evt #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sga_wr    (sga_wr),
        .sga_val   (sga_val),
        .step      (accept_minor),
        .last_iter (last_iter),
        .half_hit  (half_hit),
        .half_ie   (half_ie),
        .major_ie  (major_ie),
        .req_dis   (req_dis),
        .link_en   (link_en_o),
        .sg_en     (sg_en_o),
        .evt       (evt),
        .sga       (sg_fetch_addr)
    );

    assign active_o       = (state == CH_BUSY);
    assign done_o         = (state == CH_DONE);
    assign irq_half       = evt.half;
    assign irq_major      = evt.major;
    assign req_en_clr     = evt.req_clr;
    assign link_start_out = evt.link;
    assign sg_fetch_req   = evt.sg_go;
    assign sg_align_err   = evt.sg_bad;

    AST_MAJOR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_major |-> done_o); // R6
    AST_HALF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_half |-> (biter_o > ITER_W'(1))); // R5
    AST_ACTIVE_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_o && done_o)); // R1

endmodule

// File: tb/dma_major_ctl_bench.sv
module dma_major_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IW = 5;
    localparam int LW = 6;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_start = 0, cfg_done = 0, cfg_link_en = 0, cfg_sg_en = 0;
    logic cfg_half_ie = 0, cfg_major_ie = 0, cfg_req_dis = 0;
    logic [LW-1:0] cfg_link_ch = '0;
    logic iter_wr = 0;
    logic [IW-1:0] iter_val = '0;
    logic sga_wr = 0;
    logic [AW-1:0] sga_val = '0;
    logic link_start_in = 0, svc_begin = 0, minor_done = 0, xfer_err = 0;

    logic start_o, active_o, done_o, link_en_o, sg_en_o;
    logic [IW-1:0] citer_o, biter_o;
    logic irq_half, irq_major, req_en_clr, link_start_out, sg_fetch_req, sg_align_err;
    logic [LW-1:0] link_target;
    logic [AW-1:0] sg_fetch_addr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_major_ctl #(.ITER_W(IW), .LINK_W(LW), .ADDR_W(AW), .DESC_BYTES(32)) u_dma_major_ctl (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_done(cfg_done),
        .cfg_link_en(cfg_link_en), .cfg_sg_en(cfg_sg_en), .cfg_half_ie(cfg_half_ie),
        .cfg_major_ie(cfg_major_ie), .cfg_req_dis(cfg_req_dis), .cfg_link_ch(cfg_link_ch),
        .iter_wr(iter_wr), .iter_val(iter_val), .sga_wr(sga_wr), .sga_val(sga_val),
        .link_start_in(link_start_in), .svc_begin(svc_begin), .minor_done(minor_done),
        .xfer_err(xfer_err),
        .start_o(start_o), .active_o(active_o), .done_o(done_o), .link_en_o(link_en_o),
        .sg_en_o(sg_en_o), .citer_o(citer_o), .biter_o(biter_o), .irq_half(irq_half),
        .irq_major(irq_major), .req_en_clr(req_en_clr), .link_start_out(link_start_out),
        .link_target(link_target), .sg_fetch_req(sg_fetch_req), .sg_fetch_addr(sg_fetch_addr),
        .sg_align_err(sg_align_err)
    );

    // Behavioural reference: 0 idle, 1 busy, 2 done
    int m_state, m_start, m_le, m_se, m_hie, m_mie, m_rd, m_lch, m_citer, m_biter, m_sga;
    int m_half, m_major, m_rclr, m_link, m_sgo, m_sbad;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_start = 0; m_le = 0; m_se = 0; m_hie = 0; m_mie = 0; m_rd = 0;
            m_lch = 0; m_citer = 0; m_biter = 0; m_sga = 0;
            m_half = 0; m_major = 0; m_rclr = 0; m_link = 0; m_sgo = 0; m_sbad = 0;
        end else begin
            int acc_svc, acc_min, lst, newc, was_done, nstate;
            acc_svc  = (m_state != 1) && svc_begin;
            acc_min  = (m_state == 1) && minor_done && !xfer_err;
            lst      = (m_citer <= 1);
            newc     = lst ? 0 : m_citer - 1;
            was_done = (m_state == 2);
            m_half = 0; m_major = 0; m_rclr = 0; m_link = 0; m_sgo = 0; m_sbad = 0;
            if (acc_min) begin
                m_half  = m_hie && (m_biter >= 2) && (newc == m_biter / 2);
                m_major = m_mie && lst;
                m_rclr  = m_rd && lst;
                m_link  = m_le && lst;
                m_sgo   = m_se && lst && (m_sga % 32 == 0);
                m_sbad  = m_se && lst && (m_sga % 32 != 0);
            end
            nstate = m_state;
            if (m_state == 1) begin
                if (xfer_err) nstate = 0;
                else if (minor_done) nstate = lst ? 2 : 0;
            end else if (svc_begin) nstate = 1;
            else if (cfg_wr && m_state == 0 && cfg_done) nstate = 2;
            else if (cfg_wr && m_state == 2 && !cfg_done) nstate = 0;
            if (acc_svc) m_start = 0;
            else if (link_start_in) m_start = 1;
            else if (cfg_wr) m_start = cfg_start;
            if (cfg_wr) begin
                m_le = cfg_link_en && !was_done;
                m_se = cfg_sg_en && !was_done;
                m_hie = cfg_half_ie; m_mie = cfg_major_ie; m_rd = cfg_req_dis;
                m_lch = int'(cfg_link_ch);
            end
            if (acc_min) m_citer = lst ? m_biter : newc;
            else if (iter_wr) begin m_citer = int'(iter_val); m_biter = int'(iter_val); end
            if (sga_wr) m_sga = int'(sga_val);
            m_state = nstate;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R1 done_o", int'(done_o), int'(m_state == 2));
        check("R3 active_o", int'(active_o), int'(m_state == 1));
        check("R4 start_o", int'(start_o), m_start);
        check("R2 link_en_o", int'(link_en_o), m_le);
        check("R2 sg_en_o", int'(sg_en_o), m_se);
        check("R10 citer_o", int'(citer_o), m_citer);
        check("R10 biter_o", int'(biter_o), m_biter);
        check("R5 irq_half", int'(irq_half), m_half);
        check("R6 irq_major", int'(irq_major), m_major);
        check("R7 req_en_clr", int'(req_en_clr), m_rclr);
        check("R8 link_start_out", int'(link_start_out), m_link);
        check("R8 link_target", int'(link_target), m_lch);
        check("R9 sg_fetch_req", int'(sg_fetch_req), m_sgo);
        check("R9 sg_fetch_addr", int'(sg_fetch_addr), m_sga);
        check("R11 sg_align_err", int'(sg_align_err), m_sbad);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        cfg_wr = 0; iter_wr = 0; sga_wr = 0; link_start_in = 0;
        svc_begin = 0; minor_done = 0; xfer_err = 0;
    endtask

    task automatic cfg(input logic st, input logic dn, input logic le, input logic se,
                       input logic hie, input logic mie, input logic rd, input int ch);
        cfg_wr = 1; cfg_start = st; cfg_done = dn; cfg_link_en = le; cfg_sg_en = se;
        cfg_half_ie = hie; cfg_major_ie = mie; cfg_req_dis = rd; cfg_link_ch = LW'(ch);
        tick();
    endtask

    task automatic set_iter(input int v);
        iter_wr = 1; iter_val = IW'(v); tick();
    endtask

    task automatic set_sga(input int v);
        sga_wr = 1; sga_val = AW'(v); tick();
    endtask

    task automatic svc();
        svc_begin = 1; tick();
    endtask

    task automatic minor();
        minor_done = 1; tick();
    endtask

    task automatic loop_once();
        svc(); minor(); tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int halves;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R13 reset state
        check("R13 reset idle", int'(active_o | done_o | start_o), 0);
        check("R13 reset counts", int'(citer_o) + int'(biter_o), 0);

        // Main run: count 4, all events on, link to channel 37, aligned pointer
        set_iter(4);
        set_sga(16'h0040);
        cfg(1, 0, 1, 1, 1, 1, 1, 37);
        check("R4 start after write", int'(start_o), 1);
        svc();
        check("R4 start cleared on service", int'(start_o), 0);
        minor(); tick();
        svc(); minor();
        check("R5 half at count 2", int'(irq_half), 1);
        tick();
        svc(); minor(); tick();
        svc(); minor();
        // R12 all completion pulses coincide
        check("R12 coincident pulses",
              int'(irq_major & req_en_clr & link_start_out & sg_fetch_req & done_o), 1);
        check("R10 reload after last", int'(citer_o), 4);
        tick();
        check("R12 pulses end after one cycle", int'(irq_major | link_start_out | sg_fetch_req), 0);

        // R2 forced zero while done
        cfg(0, 1, 1, 1, 1, 1, 1, 37);
        check("R2 link forced off", int'(link_en_o | sg_en_o), 0);
        cfg(0, 0, 0, 0, 1, 1, 0, 37);
        check("R1 done cleared by write", int'(done_o), 0);
        cfg(0, 0, 1, 0, 1, 1, 0, 12);
        check("R2 link set after clear", int'(link_en_o), 1);

        // Count 1: no half interrupt (R5), immediate completion
        set_iter(1);
        loop_once();
        // R1 service from done clears done
        svc();
        check("R1 done cleared by service", int'(done_o), 0);
        minor();

        // Count 3: half at 1; count 2: half at 1
        cfg(0, 0, 0, 0, 1, 1, 0, 5);
        set_iter(3);
        repeat (3) loop_once();
        set_iter(2);
        repeat (2) loop_once();

        // R3 error ends service without count change
        cfg(0, 0, 0, 0, 1, 1, 0, 5);
        set_iter(6);
        svc();
        xfer_err = 1; minor_done = 1; tick();
        check("R3 error keeps count", int'(citer_o), 6);
        minor(); // ignored while idle
        svc(); svc(); // second ignored while busy
        minor();

        // R11 misaligned pointer
        set_sga(16'h0044);
        cfg(0, 0, 0, 1, 0, 0, 0, 0);
        set_iter(1);
        svc(); minor();
        check("R11 align error", int'(sg_align_err), 1);
        check("R11 no fetch", int'(sg_fetch_req), 0);
        tick();

        // R4 start from link input, and service wins over a same-cycle set
        link_start_in = 1; tick();
        check("R4 start from link", int'(start_o), 1);
        cfg_wr = 1; cfg_start = 1; cfg_done = 1; svc_begin = 1; tick();
        check("R4 service clear wins", int'(start_o), 0);
        minor();

        // R10 count 0 completes at once
        cfg(0, 0, 0, 0, 1, 1, 1, 0);
        set_iter(0);
        svc(); minor();
        check("R10 zero count completes", int'(done_o), 1);
        check("R7 request clear", int'(req_en_clr), 1);
        tick();

        // R7 off: no clear; R1 idle->done write
        cfg(0, 0, 0, 0, 1, 1, 0, 0);
        cfg(0, 1, 0, 0, 1, 1, 0, 0);
        check("R1 done set by write", int'(done_o), 1);
        cfg(0, 0, 0, 0, 1, 1, 0, 0);

        // Full-range count 31, half at 15 (R5)
        set_iter(31);
        halves = 0;
        for (int i = 0; i < 31; i++) begin
            svc(); minor();
            halves += int'(irq_half);
            if (i == 15) check("R5 half at 15", int'(citer_o), 15);
            tick();
        end
        check("R5 single half pulse", halves, 1);
        check("R1 done after 31", int'(done_o), 1);

        repeat (3) tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule